// File: doc/BRIEF.md
# Dual Address Pointer with Per-Pointer Count Direction

This block holds two address pointers of parameterized width (16 bits by default) plus a small control register. One bit of the control register picks the active pointer. Two further bits give each pointer its own count direction, so a single step command can move the active pointer up or down.

A CPU core drives it directly. Software writes the control register to pick a pointer and set the directions. The datapath loads the active pointer in parallel. An instruction strobe steps the active pointer by one. Both pointers can be read at all times, and the active pointer also has its own output.

Top module: `dptr_pair`

## Requirements
- R1: After reset both pointers and every control-register bit read 0.
- R2: Control register layout: bit 0 is the pointer select (0 = pointer 0, 1 = pointer 1). Bit 6 is the direction of pointer 0 and bit 7 is the direction of pointer 1 (1 = count down). All other bits read 0. A write with `ctl_we_i` takes effect on the next clock edge.
- R3: With `step_i` high and the active pointer's direction bit at 0, the active pointer increases by 1 on the next edge.
- R4: With `step_i` high and the active pointer's direction bit at 1, the active pointer decreases by 1 on the next edge.
- R5: Stepping wraps modulo 2^W: the all-ones value plus 1 gives 0, and 0 minus 1 gives all ones.
- R6: `ld_i` writes `ld_data_i` into the active pointer only.
- R7: When `ld_i` and `step_i` are both high in the same cycle, the load wins and no step happens.
- R8: The inactive pointer never changes on a load or a step.
- R9: `act_o` always equals the pointer that the current select bit chooses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ld_i | input | 1 | Load the active pointer |
| ld_data_i | input | W | Load value |
| step_i | input | 1 | Step strobe for the active pointer |
| ctl_o | output | 8 | Control register readback |
| ptr0_o | output | W | Pointer 0 |
| ptr1_o | output | W | Pointer 1 |
| act_o | output | W | Active pointer |

## Verification
The bench builds the block with the default pointer width of 16. That width lets the wrap points 0000h and FFFFh be reached directly through loads, so both wrap directions are checked in a handful of cycles. Every combination of select bit and direction bit is driven. The bench also checks that the control register's spare bits read 0, that a load beats a simultaneous step, and that the inactive pointer stays put.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned SEL_BIT = 0;
  localparam int unsigned DIR0_BIT = 6;
  localparam int unsigned DIR1_BIT = 7;
  localparam int unsigned NPTR    = 2;

  typedef struct packed {
    logic dir1;
    logic dir0;
    logic sel;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    logic [CTL_W-1:0] v;
    v = '0;
    v[SEL_BIT]  = c.sel;
    v[DIR0_BIT] = c.dir0;
    v[DIR1_BIT] = c.dir1;
    return v;
  endfunction
endpackage

// File: rtl/dptr_ctl.sv
module dptr_ctl
  import dptr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
    end else if (we_i) begin
      ctl_o.sel  <= wdata_i[SEL_BIT];
      ctl_o.dir0 <= wdata_i[DIR0_BIT];
      ctl_o.dir1 <= wdata_i[DIR1_BIT];
    end
  end
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] step_val;

  // modulo-2^W wrap via natural overflow
  always_comb begin
    step_val = down_i ? q_o - W'(1) : q_o + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (en_i) begin
      if (ld_i)        q_o <= ld_data_i;
      else if (step_i) q_o <= step_val;
    end
  end
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
  import dptr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             ld_i,
  input  logic [W-1:0]     ld_data_i,
  input  logic             step_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [W-1:0]     ptr0_o,
  output logic [W-1:0]     ptr1_o,
  output logic [W-1:0]     act_o
);
  ctl_t ctl;
  logic [NPTR-1:0] dir;
  logic [W-1:0] ptr [NPTR];

  dptr_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  assign dir = {ctl.dir1, ctl.dir0};

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    dptr_reg #(.W(W)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ctl.sel == 1'(i)),
      .ld_i      (ld_i),
      .ld_data_i (ld_data_i),
      .step_i    (step_i),
      .down_i    (dir[i]),
      .q_o       (ptr[i])
    );
  end

  assign ctl_o  = ctl_pack(ctl);
  assign ptr0_o = ptr[0];
  assign ptr1_o = ptr[1];
  assign act_o  = ctl.sel ? ptr[1] : ptr[0];
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk
  import dptr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_i,
  input logic [W-1:0]     ld_data_i,
  input logic             step_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_o,
  input logic [W-1:0]     ptr0_o,
  input logic [W-1:0]     ptr1_o,
  input logic [W-1:0]     act_o
);
  p_spare_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o & 8'b0011_1110) == '0);

  p_step_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !ctl_we_i && !ctl_o[SEL_BIT] && !ctl_o[DIR0_BIT])
      |=> ptr0_o == $past(ptr0_o) + W'(1));

  p_step_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !ctl_we_i && ctl_o[SEL_BIT] && ctl_o[DIR1_BIT])
      |=> ptr1_o == $past(ptr1_o) - W'(1));

  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !ctl_we_i) |=> act_o == $past(ld_data_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[SEL_BIT] |=> $stable(ptr0_o) || $past(ctl_we_i));

  p_inactive_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[SEL_BIT] |=> $stable(ptr1_o) || $past(ctl_we_i));

  p_act_mux_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o == (ctl_o[SEL_BIT] ? ptr1_o : ptr0_o));
endmodule

bind dptr_pair dptr_pair_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld_i      (ld_i),
  .ld_data_i (ld_data_i),
  .step_i    (step_i),
  .ctl_we_i  (ctl_we_i),
  .ctl_o     (ctl_o),
  .ptr0_o    (ptr0_o),
  .ptr1_o    (ptr1_o),
  .act_o     (act_o)
);

// File: tb/dptr_pair_tb_top.sv
module dptr_pair_tb_top;
  localparam int unsigned W = 16;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         ctl_we = 0;
  logic [7:0]   ctl_wdata = 0;
  logic         ld = 0;
  logic [W-1:0] ld_data = 0;
  logic         step = 0;
  logic [7:0]   ctl;
  logic [W-1:0] p0, p1, act;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dptr_pair #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ld_i(ld), .ld_data_i(ld_data), .step_i(step),
    .ctl_o(ctl), .ptr0_o(p0), .ptr1_o(p1), .act_o(act)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, registers update at next posedge, sample at following negedge
  task automatic cyc(logic we, logic [7:0] wd, logic l, logic [W-1:0] d, logic s);
    ctl_we = we; ctl_wdata = wd; ld = l; ld_data = d; step = s;
    @(negedge clk);
    ctl_we = 0; ld = 0; step = 0;
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl, 0);
    chk("R1 p0", p0, 0);
    chk("R1 p1", p1, 0);
  endtask

  task automatic t_ctl;
    cyc(1, 8'hFF, 0, 0, 0);
    chk("R2 ctl all", ctl, 8'hC1);
    cyc(1, 8'h40, 0, 0, 0);
    chk("R2 ctl dir0", ctl, 8'h40);
    cyc(1, 8'h00, 0, 0, 0);
    chk("R2 ctl clr", ctl, 8'h00);
  endtask

  task automatic t_up;
    cyc(0, 0, 1, 16'h1234, 0);
    chk("R6 load p0", p0, 16'h1234);
    chk("R8 p1 held", p1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R3 up p0", p0, 16'h1235);
    cyc(1, 8'h01, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R3 up p1", p1, 16'h0001);
    chk("R8 p0 held", p0, 16'h1235);
    chk("R9 act p1", act, 16'h0001);
  endtask

  task automatic t_down;
    cyc(1, 8'h40, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 down p0", p0, 16'h1234);
    chk("R8 p1 held dn", p1, 16'h0001);
    cyc(1, 8'h81, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R4 down p1", p1, 16'h0000);
    chk("R9 act", act, 16'h0000);
    cyc(1, 8'h01, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R3 dir1 clear up", p1, 16'h0001);
  endtask

  task automatic t_wrap;
    cyc(1, 8'h81, 0, 0, 0);
    cyc(0, 0, 1, 16'h0000, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 wrap down", p1, 16'hFFFF);
    cyc(1, 8'h00, 0, 0, 0);
    cyc(0, 0, 1, 16'hFFFF, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 wrap up", p0, 16'h0000);
    chk("R8 p1 held wrap", p1, 16'hFFFF);
  endtask

  task automatic t_prio;
    cyc(0, 0, 1, 16'hABCD, 1);
    chk("R7 load wins p0", p0, 16'hABCD);
    cyc(1, 8'h81, 0, 0, 0);
    cyc(0, 0, 1, 16'h5555, 1);
    chk("R7 load wins p1", p1, 16'h5555);
    chk("R6 p0 untouched", p0, 16'hABCD);
    chk("R9 act sel1", act, 16'h5555);
    cyc(1, 8'h00, 0, 0, 0);
    chk("R9 act sel0", act, 16'hABCD);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_up();
    t_down();
    t_wrap();
    t_prio();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule